// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block runs after a program or erase command has been sent to a flash device. It reads the device status over a simple request/valid read port, again and again, until the operation finishes. It then raises a one-cycle `done` with a classified result code.

It supports two ways of detecting completion:
- **Ready-bit mode.** One status read per check. The check finishes when a ready bit is set, and the remaining status bits are then decoded into an error class.
- **Toggle mode.** Two status reads per check, back to back. The check finishes when a toggling bit reads the same value in both reads.

Elapsed time is counted in microsecond ticks from the start pulse. Before every check, the current count is captured. That captured value is compared against two limits:
- a typical limit, equal to a per-operation unit shifted left by a typical exponent;
- a maximum limit, equal to the typical limit shifted left again by a maximum exponent.

The unit is `MS_TICKS` ticks for erase and one tick for both program kinds. If a check ends past the maximum limit without completion, the block gives up and reports a timeout. For each operation kind it keeps two saturating counters: how often the typical limit was overrun and how often the maximum limit was overrun.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are 0, `err_code` is 0 (none), and all overrun counters are 0.
- R2: The operation kind, the mode and both limits are taken from the inputs on the `start` edge while idle. A `start` while busy is ignored, along with any change to the inputs it carries. Operation kinds are 0 erase, 1 word program and 2 buffered program; a value of 3 is taken as buffered.
- R3: In ready-bit mode a check finishes only when status bit 7 is set. Before decoding, bits 15:8, bit 7 and bit 0 are masked off, and status bits are ignored while bit 7 is clear.
- R4: Once ready-bit mode has finished, the masked status is decoded in this priority order:
  - bit 1 gives code 1 (protect);
  - otherwise bit 4 gives code 2 (program);
  - otherwise bit 5 gives code 3 (erase);
  - otherwise any remaining bit (6, 3 or 2) gives code 4 (other);
  - with no bit set, the code is 0 (none).
- R5: In toggle mode each check issues two reads, and it finishes with code 0 when status bit 6 is equal in both reads. No other status bit matters in this mode.
- R6: The typical limit is unit << typical exponent and the maximum limit is typical << maximum exponent; a shift that overflows saturates to all ones. The elapsed count is captured before each check's first read, and a limit counts as passed only when the captured value is strictly greater than it.
- R7: The typical overrun counter of the running operation kind increments once per operation, at the first check whose captured time passes the typical limit.
- R8: A check whose captured time passes the maximum limit ends the operation. It increments that kind's maximum overrun counter, and if the device has not finished, the result is code 5 (timeout).
- R9: When completion and the maximum-limit crossing fall in the same check, the completion result is reported and the maximum overrun counter still increments. If the typical limit is passed for the first time in that check, the typical counter also increments.
- R10: Every overrun counter saturates at all ones.
- R11: `done` is high for exactly one cycle, while `busy` is low. `err_code` changes only together with `done` and holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling; sampled only while idle |
| op_sel | input | 2 | Operation kind: 0 erase, 1 word program, 2 buffered program (3 taken as 2) |
| toggle_mode | input | 1 | 0 selects ready-bit mode, 1 selects toggle mode |
| typ_exp | input | NOPS*EXP_W | Typical exponents, one field per operation kind, erase in the lowest field |
| max_exp | input | NOPS*EXP_W | Maximum exponents, same layout as `typ_exp` |
| tick_us | input | 1 | One-cycle microsecond tick |
| rd_req | output | 1 | One-cycle status read request |
| rd_valid | input | 1 | Status read data is valid |
| rd_data | input | STAT_W | Status read data |
| busy | output | 1 | Operation is being polled |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 none, 1 protect, 2 program, 3 erase, 4 other, 5 timeout |
| typ_over_cnt | output | NOPS*CW | Typical overrun counters, erase in the lowest field |
| max_over_cnt | output | NOPS*CW | Maximum overrun counters, erase in the lowest field |

## Verification
The important coincidence is a single check in which the device reports completion and the captured time also passes the maximum limit, and the typical limit may be passed for the first time in that same check. To provoke it, the limits are made so small (one tick each) that the second check lands past both of them while the device model turns ready at exactly that read. The case is judged as follows:
- The reported code must be the decoded status and not a timeout.
- Both counters of that operation kind must each move by exactly one.

A second run with the protect bit set checks that decode priority still holds in this overlap.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  localparam int STAT_W   = 16;
  localparam int TIME_W   = 32;
  localparam int NOPS     = 3;
  localparam int OPW      = $clog2(NOPS);

  // Status bit positions used by the decoder
  localparam int RDY_BIT  = 7;
  localparam int PROT_BIT = 1;
  localparam int PGM_BIT  = 4;
  localparam int ERS_BIT  = 5;
  localparam int TGL_BIT  = 6;

  // Bits left after dropping the upper byte, the ready bit and bit 0
  localparam logic [STAT_W-1:0] KEEP_MASK = STAT_W'(8'h7E);

  localparam logic [OPW-1:0] OP_ERASE = OPW'(0);
  localparam logic [OPW-1:0] OP_WORD  = OPW'(1);
  localparam logic [OPW-1:0] OP_BUF   = OPW'(2);

  typedef logic [TIME_W-1:0] tval_t;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_PROTECT = 3'd1,
    ERR_PROGRAM = 3'd2,
    ERR_ERASE   = 3'd3,
    ERR_OTHER   = 3'd4,
    ERR_TIMEOUT = 3'd5
  } err_e;

  // Left shift that sticks at all ones once the top bit would fall off
  function automatic tval_t shl_sat(tval_t v, int unsigned sh);
    tval_t r;
    r = v;
    for (int i = 0; i < 64; i++) begin
      if (i < sh) r = r[TIME_W-1] ? '1 : (r << 1);
    end
    return r;
  endfunction

  // Priority classification of a ready status word
  function automatic err_e classify(logic [STAT_W-1:0] st);
    logic [STAT_W-1:0] m;
    m = st & KEEP_MASK;
    if (m[PROT_BIT])     return ERR_PROTECT;
    else if (m[PGM_BIT]) return ERR_PROGRAM;
    else if (m[ERS_BIT]) return ERR_ERASE;
    else if (|m)         return ERR_OTHER;
    else                 return ERR_NONE;
  endfunction

endpackage

// File: rtl/fdp_limit_calc.sv
module fdp_limit_calc
  import fdp_pkg::*;
#(
  parameter int EXP_W    = 6,
  parameter int MS_TICKS = 1000
) (
  input  logic [OPW-1:0]        op_idx,
  input  logic [NOPS*EXP_W-1:0] typ_exp,
  input  logic [NOPS*EXP_W-1:0] max_exp,
  output tval_t                 typ_lim,
  output tval_t                 max_lim
);

  tval_t typ_tab [NOPS];
  tval_t max_tab [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    localparam tval_t UNIT = (g == int'(OP_ERASE)) ? tval_t'(MS_TICKS) : tval_t'(1);
    always_comb begin
      typ_tab[g] = shl_sat(UNIT, int'(typ_exp[g*EXP_W +: EXP_W]));
      max_tab[g] = shl_sat(typ_tab[g], int'(max_exp[g*EXP_W +: EXP_W]));
    end
  end

  assign typ_lim = typ_tab[op_idx];
  assign max_lim = max_tab[op_idx];

endmodule

// File: rtl/fdp_status_decode.sv
module fdp_status_decode
  import fdp_pkg::*;
(
  input  logic              toggle_mode,
  input  logic [STAT_W-1:0] rd_first,
  input  logic [STAT_W-1:0] rd_second,
  output logic              finished,
  output err_e              cls
);

  always_comb begin
    if (toggle_mode) begin
      finished = (rd_first[TGL_BIT] == rd_second[TGL_BIT]);
      cls      = ERR_NONE;
    end else begin
      finished = rd_first[RDY_BIT];
      cls      = rd_first[RDY_BIT] ? classify(rd_first) : ERR_NONE;
    end
  end

endmodule

// File: rtl/fdp_overrun_counters.sv
module fdp_overrun_counters
  import fdp_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPW-1:0]     op_idx,
  input  logic               inc_typ,
  input  logic               inc_max,
  output logic [NOPS*CW-1:0] typ_cnt,
  output logic [NOPS*CW-1:0] max_cnt
);

  localparam logic [CW-1:0] TOP = '1;

  for (genvar g = 0; g < NOPS; g++) begin : g_cnt
    logic [CW-1:0] t_q, m_q;
    logic          sel;
    assign sel = (op_idx == OPW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        m_q <= '0;
      end else begin
        if (sel && inc_typ && t_q != TOP) t_q <= t_q + 1'b1;
        if (sel && inc_max && m_q != TOP) m_q <= m_q + 1'b1;
      end
    end

    assign typ_cnt[g*CW +: CW] = t_q;
    assign max_cnt[g*CW +: CW] = m_q;
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int EXP_W    = 6,
  parameter int MS_TICKS = 1000,
  parameter int CW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op_sel,
  input  logic                  toggle_mode,
  input  logic [NOPS*EXP_W-1:0] typ_exp,
  input  logic [NOPS*EXP_W-1:0] max_exp,
  input  logic                  tick_us,
  output logic                  rd_req,
  input  logic                  rd_valid,
  input  logic [STAT_W-1:0]     rd_data,
  output logic                  busy,
  output logic                  done,
  output logic [2:0]            err_code,
  output logic [NOPS*CW-1:0]    typ_over_cnt,
  output logic [NOPS*CW-1:0]    max_over_cnt
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE0, S_WAIT0, S_ISSUE1, S_WAIT1, S_EVAL
  } st_e;

  st_e               state;
  logic [OPW-1:0]    op_q;
  logic              tgl_q;
  tval_t             typ_lim_q, max_lim_q;
  tval_t             elapsed, snap;
  logic              typ_seen;
  logic [STAT_W-1:0] rd0_q, rd1_q;
  logic              done_q;
  err_e              err_q;

  logic [OPW-1:0]    op_in;
  tval_t             typ_lim_c, max_lim_c;
  logic              fin;
  err_e              cls;

  // Named internal events
  logic evt_check, evt_typ_cross, evt_max_cross, evt_finish, evt_end;

  assign op_in = (op_sel > 2'(OP_BUF)) ? OP_BUF : OPW'(op_sel);

  fdp_limit_calc #(.EXP_W(EXP_W), .MS_TICKS(MS_TICKS)) u_lim (
    .op_idx  (op_in),
    .typ_exp (typ_exp),
    .max_exp (max_exp),
    .typ_lim (typ_lim_c),
    .max_lim (max_lim_c)
  );

  fdp_status_decode u_dec (
    .toggle_mode (tgl_q),
    .rd_first    (rd0_q),
    .rd_second   (rd1_q),
    .finished    (fin),
    .cls         (cls)
  );

  assign evt_check     = (state == S_EVAL);
  assign evt_typ_cross = evt_check && (snap > typ_lim_q) && !typ_seen;
  assign evt_max_cross = evt_check && (snap > max_lim_q);
  assign evt_finish    = evt_check && fin;
  assign evt_end       = evt_finish || evt_max_cross;

  fdp_overrun_counters #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_idx  (op_q),
    .inc_typ (evt_typ_cross),
    .inc_max (evt_max_cross),
    .typ_cnt (typ_over_cnt),
    .max_cnt (max_over_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= '0;
      tgl_q     <= 1'b0;
      typ_lim_q <= '0;
      max_lim_q <= '0;
      elapsed   <= '0;
      snap      <= '0;
      typ_seen  <= 1'b0;
      rd0_q     <= '0;
      rd1_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          op_q      <= op_in;
          tgl_q     <= toggle_mode;
          typ_lim_q <= typ_lim_c;
          max_lim_q <= max_lim_c;
          elapsed   <= '0;
          typ_seen  <= 1'b0;
          state     <= S_ISSUE0;
        end
      end else begin
        if (tick_us && elapsed != '1) elapsed <= elapsed + 1'b1;
        case (state)
          S_ISSUE0: begin
            snap  <= elapsed;
            state <= S_WAIT0;
          end
          S_WAIT0: if (rd_valid) begin
            rd0_q <= rd_data;
            state <= tgl_q ? S_ISSUE1 : S_EVAL;
          end
          S_ISSUE1: state <= S_WAIT1;
          S_WAIT1: if (rd_valid) begin
            rd1_q <= rd_data;
            state <= S_EVAL;
          end
          S_EVAL: begin
            if (evt_typ_cross) typ_seen <= 1'b1;
            if (evt_end) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= fin ? cls : ERR_TIMEOUT;
            end else begin
              state <= S_ISSUE0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign rd_req   = (state == S_ISSUE0) || (state == S_ISSUE1);
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign err_code = err_q;

endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int NOPS = 3,
  parameter int CW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               rd_req,
  input logic [2:0]         err_code,
  input logic               evt_max_cross,
  input logic [NOPS*CW-1:0] typ_cnt,
  input logic [NOPS*CW-1:0] max_cnt
);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err_code));

  p_timeout_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd5) |-> $past(evt_max_cross));

  p_no_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  for (genvar g = 0; g < NOPS; g++) begin : g_mono
    p_typ_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (typ_cnt[g*CW +: CW] != $past(typ_cnt[g*CW +: CW])) |->
        (typ_cnt[g*CW +: CW] == $past(typ_cnt[g*CW +: CW]) + 1'b1));
    p_max_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (max_cnt[g*CW +: CW] != $past(max_cnt[g*CW +: CW])) |->
        (max_cnt[g*CW +: CW] == $past(max_cnt[g*CW +: CW]) + 1'b1));
  end

endmodule

bind flash_done_poller fdp_checker #(.NOPS(fdp_pkg::NOPS), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .rd_req        (rd_req),
  .err_code      (err_code),
  .evt_max_cross (evt_max_cross),
  .typ_cnt       (typ_over_cnt),
  .max_cnt       (max_over_cnt)
);

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;
  import fdp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W      = 6;
  localparam int MS_TICKS   = 3;
  localparam int CW         = 2;
  localparam int CMAX       = (1 << CW) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [1:0]            op_sel = '0;
  logic                  toggle_mode = 1'b0;
  logic [NOPS*EXP_W-1:0] typ_exp = '0;
  logic [NOPS*EXP_W-1:0] max_exp = '0;
  logic                  tick_us = 1'b1;
  logic                  rd_req;
  logic                  rd_valid = 1'b0;
  logic [STAT_W-1:0]     rd_data = '0;
  logic                  busy, done;
  logic [2:0]            err_code;
  logic [NOPS*CW-1:0]    typ_over_cnt, max_over_cnt;

  flash_done_poller #(.EXP_W(EXP_W), .MS_TICKS(MS_TICKS), .CW(CW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int et [NOPS];
  int em [NOPS];

  // Flash status model
  int          m_reads = 0;
  int          m_base = 0;
  int          m_ready_after = 0;
  int          m_toggle_reads = 0;
  logic        m_tgl = 1'b0;
  logic [15:0] m_final = '0;

  function automatic logic [15:0] model_word(int idx);
    logic [15:0] w;
    if (m_tgl) begin
      w = 16'h0090;
      if (idx < m_toggle_reads) w[6] = idx[0];
    end else begin
      w = (idx < m_ready_after) ? 16'h0031 : m_final;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= model_word(m_reads - m_base);
      m_reads  <= m_reads + 1;
    end else begin
      rd_valid <= 1'b0;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_counters(string req);
    for (int g = 0; g < NOPS; g++) begin
      check({req, " typ counter"}, int'(typ_over_cnt[g*CW +: CW]), et[g]);
      check({req, " max counter"}, int'(max_over_cnt[g*CW +: CW]), em[g]);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic run_op(string req, int op, bit tgl, int texp, int mexp,
                        int ready_after, logic [15:0] fin_word, int toggle_reads,
                        int exp_err, int exp_reads, bit dt, bit dm, bit inject);
    int  waited;
    int  err_seen;
    m_tgl          = tgl;
    m_ready_after  = ready_after;
    m_final        = fin_word;
    m_toggle_reads = toggle_reads;
    @(negedge clk);
    m_base      = m_reads;
    op_sel      = 2'(op);
    toggle_mode = tgl;
    typ_exp     = '0;
    max_exp     = '0;
    typ_exp[op*EXP_W +: EXP_W] = EXP_W'(texp);
    max_exp[op*EXP_W +: EXP_W] = EXP_W'(mexp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start"}, int'(busy), 1);
    if (inject) begin
      repeat (2) @(negedge clk);
      op_sel  = 2'd1;
      typ_exp = '0;
      max_exp = '0;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check({req, " done seen"}, int'(done), 1);
    err_seen = int'(err_code);
    check({req, " err_code"}, err_seen, exp_err);
    check({req, " status reads"}, m_reads - m_base, exp_reads);
    if (dt) et[op] = sat(et[op] + 1);
    if (dm) em[op] = sat(em[op] + 1);
    check_counters(req);
    @(negedge clk);
    check("R11 done one cycle", int'(done), 0);
    @(negedge clk);
    check("R11 err_code held", int'(err_code), err_seen);
  endtask

  initial begin
    for (int g = 0; g < NOPS; g++) begin
      et[g] = 0;
      em[g] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 rd_req", int'(rd_req), 0);
    check("R1 err_code", int'(err_code), 0);
    check_counters("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(busy), 0);

    // R4 priority decode (erase, wide limits, ready at first read)
    run_op("R4 protect wins",  0, 0, 10, 2, 0, 16'h00B2, 0, 1, 1, 0, 0, 0);
    run_op("R4 program wins",  0, 0, 10, 2, 0, 16'h00B0, 0, 2, 1, 0, 0, 0);
    run_op("R4 erase wins",    0, 0, 10, 2, 0, 16'h00A8, 0, 3, 1, 0, 0, 0);
    run_op("R4 other bit3",    0, 0, 10, 2, 0, 16'h0088, 0, 4, 1, 0, 0, 0);
    run_op("R4 other bit6",    0, 0, 10, 2, 0, 16'h00C0, 0, 4, 1, 0, 0, 0);
    run_op("R4 other bit2",    0, 0, 10, 2, 0, 16'h0084, 0, 4, 1, 0, 0, 0);
    // R3 masked bits and not-ready noise
    run_op("R3 masked bits",   2, 0, 10, 2, 0, 16'hFF81, 0, 0, 1, 0, 0, 0);
    run_op("R3 noise ignored", 2, 0, 10, 2, 2, 16'h0080, 0, 0, 3, 0, 0, 0);
    // R2 start while busy ignored
    run_op("R2 start ignored", 0, 0, 10, 2, 3, 16'h0080, 0, 0, 4, 0, 0, 1);
    // R5 toggle mode
    run_op("R5 toggle settles", 2, 1, 10, 4, 0, 16'h0000, 4, 0, 6, 0, 0, 0);
    run_op("R5 toggle timeout", 1, 1, 0, 2, 0, 16'h0000, 1000, 5, 4, 1, 1, 0);
    // R6/R8 erase limits in ms units, strict comparison
    run_op("R6 R8 erase timeout", 0, 0, 0, 1, 100, 16'h0080, 0, 5, 4, 1, 1, 0);
    // R7 typical counted once
    run_op("R7 typical once", 2, 0, 0, 4, 4, 16'h0080, 0, 0, 5, 1, 0, 0);
    // R9 completion and max limit in one check
    run_op("R9 same check ok",   1, 0, 0, 0, 1, 16'h0080, 0, 0, 2, 1, 1, 0);
    run_op("R9 same check prot", 1, 0, 0, 0, 1, 16'h0082, 0, 1, 2, 1, 1, 0);
    // R10 saturation
    run_op("R10 saturate a", 1, 0, 0, 0, 100, 16'h0080, 0, 5, 2, 1, 1, 0);
    run_op("R10 saturate b", 1, 0, 0, 0, 100, 16'h0080, 0, 5, 2, 1, 1, 0);
    check("R10 word typ at top", int'(typ_over_cnt[CW +: CW]), CMAX);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule